// File: doc/BRIEF.md
# CCD Horizontal Register Clock Generator

This block produces the digital timing for reading one line out of a full-frame CCD output register. Each pixel period is six clock cycles long (six sub-slots). In each pixel period the block drives three register transport phases, a one-sub-slot summing-gate pulse and a one-sub-slot sense-node reset pulse. It also produces a sample strobe and a two-bit tag that gives the class of the pixel being read. The analog drivers that turn these levels into gate voltages sit outside the block.

A line sequencer asserts the start-stop input to run one line. The block then steps through the line's fixed order of pixel classes: dummy cells first, then black reference, timing, the active pixels, timing again and black again. It raises a done pulse at the end of the line. While the start-stop input is low, the register clocks hold a static level so that vertical transfer can proceed. A horizontal binning factor, captured at line start, merges several register pixels into one output sample.

Top module: `hreg_clkgen`

## Requirements
- R1: While running, the sub-slot advances by one each clock from 0 to 5 and wraps. ph_o[0] is high in sub-slots 0,1,2, ph_o[1] in 2,3,4 and ph_o[2] in 4,5,0.
- R2: While not running (after reset, before start, after abort or after line end), ph_o = 3'b001 and sg_o, rg_o and sample_o are low.
- R3: The pixel periods of a line run in this order: N_DUMMY dummy, N_BLACK black, N_TIMING timing, N_ACTIVE active, N_TIMING timing, N_BLACK black (defaults 7, 20, 4, 3072, 4, 20, which is 3127 periods). class_o encodes dummy=0, black=1, timing=2, active=3, and reads 0 when not running.
- R4: rg_o is high for exactly sub-slot 0 of the first register pixel of each binning group.
- R5: sg_o is high for exactly sub-slot 3 of the last register pixel of each binning group. Groups are counted from the first pixel of the line. The factor bin_i is captured when the line starts, and the values 0 and 1 both mean one pixel per group.
- R6: sample_o is high in sub-slot 4 of the last register pixel of each group, and class_o gives that pixel's class in the same cycle.
- R7: line_done_o is high for one clock, in the cycle after sub-slot 5 of the final pixel. The block then stays stopped until ss_i has been low for at least one clock.
- R8: If ss_i is low at a clock edge while running, the block stops at that edge. The next start begins again at sub-slot 0 of the first dummy pixel.
- R9: From stopped with ss_i low before, the first clock edge that sees ss_i high enters sub-slot 0 of pixel 0, and running_o goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sub-slot clock (six per pixel period) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ss_i | input | 1 | Start-stop control from the line sequencer |
| bin_i | input | BIN_W | Horizontal binning factor (0 or 1 = none) |
| ph_o | output | 3 | Register transport phases |
| sg_o | output | 1 | Summing-gate pulse |
| rg_o | output | 1 | Sense-node reset pulse |
| sample_o | output | 1 | Output sample strobe |
| class_o | output | 2 | Pixel class tag |
| running_o | output | 1 | A line is being clocked out |
| line_done_o | output | 1 | One-clock end-of-line pulse |

## Verification
A behavioural model in the bench tracks the line position as a flat pixel index. Every clock it predicts every output and compares. A full unbinned line separates errors in the class boundaries from errors in the phase decode. A binned line, with the factor changed partway through, shows whether groups are counted from line start and whether the factor is captured only once. A line aborted and restarted with a zero factor tests abort, restart from pixel 0 and the zero-means-one rule. Holding ss_i high after done tests that the block waits before it re-arms.

// File: rtl/hclk_pkg.sv
package hclk_pkg;
  typedef enum logic [1:0] {
    PX_DUMMY  = 2'd0,
    PX_BLACK  = 2'd1,
    PX_TIMING = 2'd2,
    PX_ACTIVE = 2'd3
  } px_class_e;

  localparam int SLOTS = 6;
  localparam int SEGS  = 6;

  // segment order along a line: dummy, black, timing, active, timing, black
  function automatic px_class_e seg_class(logic [2:0] seg);
    case (seg)
      3'd0:         return PX_DUMMY;
      3'd1, 3'd5:   return PX_BLACK;
      3'd2, 3'd4:   return PX_TIMING;
      default:      return PX_ACTIVE;
    endcase
  endfunction
endpackage

// File: rtl/hclk_line_seq.sv
module hclk_line_seq #(
  parameter int N_DUMMY  = 7,
  parameter int N_BLACK  = 20,
  parameter int N_TIMING = 4,
  parameter int N_ACTIVE = 3072,
  parameter int BIN_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ss_i,
  input  logic [BIN_W-1:0] bin_i,
  output logic             run_o,
  output logic [2:0]       slot_o,
  output logic [2:0]       seg_o,
  output logic             grp_first_o,
  output logic             grp_last_o,
  output logic             done_o
);
  localparam int M1     = (N_DUMMY > N_BLACK) ? N_DUMMY : N_BLACK;
  localparam int M2     = (N_TIMING > N_ACTIVE) ? N_TIMING : N_ACTIVE;
  localparam int MAXLEN = (M1 > M2) ? M1 : M2;
  localparam int CW     = $clog2(MAXLEN + 1);
  localparam logic [2:0] LAST_SLOT = 3'(hclk_pkg::SLOTS - 1);
  localparam logic [2:0] LAST_SEG  = 3'(hclk_pkg::SEGS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;

  st_e              st_q;
  logic [2:0]       slot_q, seg_q;
  logic [CW-1:0]    pcnt_q;
  logic [BIN_W-1:0] bcnt_q, binq_q;
  logic             done_q;

  function automatic logic [CW-1:0] seg_last(logic [2:0] s);
    case (s)
      3'd0:       return CW'(N_DUMMY - 1);
      3'd1, 3'd5: return CW'(N_BLACK - 1);
      3'd2, 3'd4: return CW'(N_TIMING - 1);
      default:    return CW'(N_ACTIVE - 1);
    endcase
  endfunction

  logic [BIN_W-1:0] bin_eff;
  logic             slot_wrap, seg_end, grp_end;

  assign bin_eff   = (bin_i == '0) ? BIN_W'(1) : bin_i;
  assign slot_wrap = (slot_q == LAST_SLOT);
  assign seg_end   = (pcnt_q == seg_last(seg_q));
  assign grp_end   = (bcnt_q == binq_q - BIN_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      slot_q <= '0;
      seg_q  <= '0;
      pcnt_q <= '0;
      bcnt_q <= '0;
      binq_q <= BIN_W'(1);
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (ss_i) begin
            st_q   <= ST_RUN;
            slot_q <= '0;
            seg_q  <= '0;
            pcnt_q <= '0;
            bcnt_q <= '0;
            binq_q <= bin_eff;
          end
        end
        ST_RUN: begin
          if (!ss_i) begin
            st_q <= ST_IDLE;
          end else if (slot_wrap) begin
            slot_q <= '0;
            bcnt_q <= grp_end ? '0 : bcnt_q + BIN_W'(1);
            if (seg_end) begin
              pcnt_q <= '0;
              if (seg_q == LAST_SEG) begin
                st_q   <= ST_DONE;
                done_q <= 1'b1;
              end else begin
                seg_q <= seg_q + 3'd1;
              end
            end else begin
              pcnt_q <= pcnt_q + CW'(1);
            end
          end else begin
            slot_q <= slot_q + 3'd1;
          end
        end
        default: begin
          if (!ss_i) st_q <= ST_IDLE;
        end
      endcase
    end
  end

  assign run_o       = (st_q == ST_RUN);
  assign slot_o      = slot_q;
  assign seg_o       = seg_q;
  assign grp_first_o = (bcnt_q == '0);
  assign grp_last_o  = grp_end;
  assign done_o      = done_q;
endmodule

// File: rtl/hclk_phase_gen.sv
module hclk_phase_gen #(
  parameter int NPH = 3
) (
  input  logic           run_i,
  input  logic [2:0]     slot_i,
  input  logic           grp_first_i,
  input  logic           grp_last_i,
  output logic [NPH-1:0] ph_o,
  output logic           sg_o,
  output logic           rg_o,
  output logic           sample_o
);
  localparam int SHIFT = hclk_pkg::SLOTS / NPH;
  localparam int HIGH  = hclk_pkg::SLOTS / 2;

  function automatic logic in_high(logic [2:0] slot, int ofs);
    int rel;
    rel = (int'(slot) + hclk_pkg::SLOTS - ofs) % hclk_pkg::SLOTS;
    return rel < HIGH;
  endfunction

  for (genvar k = 0; k < NPH; k++) begin : g_ph
    localparam int OFS = k * SHIFT;
    // idle level: first phase high, others low
    assign ph_o[k] = run_i ? in_high(slot_i, OFS) : (k == 0);
  end

  assign rg_o     = run_i && (slot_i == 3'd0) && grp_first_i;
  assign sg_o     = run_i && (slot_i == 3'd3) && grp_last_i;
  assign sample_o = run_i && (slot_i == 3'd4) && grp_last_i;
endmodule

// File: rtl/hreg_clkgen.sv
module hreg_clkgen #(
  parameter int N_DUMMY  = 7,
  parameter int N_BLACK  = 20,
  parameter int N_TIMING = 4,
  parameter int N_ACTIVE = 3072,
  parameter int BIN_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ss_i,
  input  logic [BIN_W-1:0] bin_i,
  output logic [2:0]       ph_o,
  output logic             sg_o,
  output logic             rg_o,
  output logic             sample_o,
  output logic [1:0]       class_o,
  output logic             running_o,
  output logic             line_done_o
);
  logic       run, grp_first, grp_last;
  logic [2:0] slot, seg;

  hclk_line_seq #(
    .N_DUMMY(N_DUMMY), .N_BLACK(N_BLACK), .N_TIMING(N_TIMING),
    .N_ACTIVE(N_ACTIVE), .BIN_W(BIN_W)
  ) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .ss_i(ss_i), .bin_i(bin_i),
    .run_o(run), .slot_o(slot), .seg_o(seg),
    .grp_first_o(grp_first), .grp_last_o(grp_last), .done_o(line_done_o)
  );

  hclk_phase_gen #(.NPH(3)) u_ph (
    .run_i(run), .slot_i(slot), .grp_first_i(grp_first), .grp_last_i(grp_last),
    .ph_o(ph_o), .sg_o(sg_o), .rg_o(rg_o), .sample_o(sample_o)
  );

  assign class_o   = run ? hclk_pkg::seg_class(seg) : hclk_pkg::PX_DUMMY;
  assign running_o = run;
endmodule

// File: rtl/hreg_clkgen_chk.sv
module hreg_clkgen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ss_i,
  input logic [2:0] ph_o,
  input logic       sg_o,
  input logic       rg_o,
  input logic       sample_o,
  input logic       running_o,
  input logic       line_done_o
);
  p_phase_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o |-> ($countones(ph_o) >= 1 && $countones(ph_o) <= 2));

  p_idle_static_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> (ph_o == 3'b001 && !sg_o && !rg_o && !sample_o));

  p_rg_narrow_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |=> !rg_o);

  p_sg_narrow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_o |=> !sg_o);

  p_sg_rg_apart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sg_o && rg_o));

  p_sample_after_sg_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_o && running_o && ss_i |=> sample_o);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |=> !line_done_o);

  p_done_stopped_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done_o |-> !running_o);

  p_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    running_o && !ss_i |=> !running_o);
endmodule

bind hreg_clkgen hreg_clkgen_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ss_i(ss_i), .ph_o(ph_o), .sg_o(sg_o),
  .rg_o(rg_o), .sample_o(sample_o), .running_o(running_o),
  .line_done_o(line_done_o)
);

// File: tb/hreg_clkgen_bench.sv
module hreg_clkgen_bench;
  localparam int CLK_P = 10;
  localparam int ND = 7, NB = 20, NT = 4, NA = 3072;
  localparam int TOTAL = ND + 2*NB + 2*NT + NA;

  logic       clk = 0, rst_n = 0, ss = 0;
  logic [2:0] bin = 3'd1;
  logic [2:0] ph;
  logic       sg, rg, smp, run, done;
  logic [1:0] cls;

  hreg_clkgen u_hreg_clkgen (
    .clk_i(clk), .rst_ni(rst_n), .ss_i(ss), .bin_i(bin),
    .ph_o(ph), .sg_o(sg), .rg_o(rg), .sample_o(smp), .class_o(cls),
    .running_o(run), .line_done_o(done)
  );

  always #(CLK_P/2) clk = ~clk;

  int total = 0, bad = 0;
  int n_smp = 0, n_act = 0;

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  // reference model: 0 idle, 1 run, 2 done
  int m_st = 0, m_slot = 0, m_pix = 0, m_bin = 1, m_bcnt = 0;
  bit m_done = 0;

  function automatic int class_of(int p);
    if (p < ND) return 0;
    if (p < ND+NB) return 1;
    if (p < ND+NB+NT) return 2;
    if (p < ND+NB+NT+NA) return 3;
    if (p < ND+NB+2*NT+NA) return 2;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_slot = 0; m_pix = 0; m_bin = 1; m_bcnt = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (m_st)
        0: if (ss) begin
             m_st = 1; m_slot = 0; m_pix = 0; m_bcnt = 0;
             m_bin = (bin == 0) ? 1 : int'(bin);
           end
        1: if (!ss) m_st = 0;
           else if (m_slot == 5) begin
             m_slot = 0;
             m_bcnt = (m_bcnt + 1) % m_bin;
             if (m_pix == TOTAL-1) begin m_st = 2; m_done = 1; end
             else m_pix++;
           end else m_slot++;
        default: if (!ss) m_st = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit r;
      r = (m_st == 1);
      chk("R9 running", run, r);
      for (int k = 0; k < 3; k++)
        chk(r ? "R1 phase" : "R2 idle phase", ph[k],
            r ? int'(((m_slot + 6 - 2*k) % 6) < 3) : int'(k == 0));
      chk("R4 reset gate", rg, int'(r && m_slot == 0 && m_bcnt == 0));
      chk("R5 summing gate", sg, int'(r && m_slot == 3 && m_bcnt == m_bin-1));
      chk("R6 sample", smp, int'(r && m_slot == 4 && m_bcnt == m_bin-1));
      chk("R3 class", cls, r ? class_of(m_pix) : 0);
      chk("R7 line done", done, int'(m_done));
      if (smp) begin
        n_smp++;
        if (cls == 2'd3) n_act++;
      end
    end
  end

  task automatic wait_done();
    do @(negedge clk); while (!done);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int s0, a0;
    repeat (3) @(negedge clk);
    chk("R2 reset ph", ph, 1);
    chk("R2 reset sg/rg", {30'd0, sg, rg}, 0);
    chk("R9 reset running", run, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // unbinned full line, then hold ss high past done
    s0 = n_smp; a0 = n_act;
    bin = 3'd1; ss = 1;
    wait_done();
    repeat (20) @(negedge clk);
    chk("R7 no rearm while ss high", run, 0);
    chk("R6 samples per line", n_smp - s0, TOTAL);
    chk("R3 active samples", n_act - a0, NA);
    ss = 0;
    repeat (4) @(negedge clk);

    // bin by 3, factor changed mid-line must not take effect
    s0 = n_smp;
    bin = 3'd3; ss = 1;
    repeat (100) @(negedge clk);
    bin = 3'd5;
    wait_done();
    @(negedge clk);
    chk("R5 binned samples", n_smp - s0, TOTAL / 3);
    ss = 0;
    repeat (4) @(negedge clk);

    // zero factor, abort mid-line then restart
    bin = 3'd0; ss = 1;
    repeat (500) @(negedge clk);
    ss = 0;
    @(negedge clk);
    chk("R8 abort stops", run, 0);
    repeat (5) @(negedge clk);
    s0 = n_smp;
    ss = 1;
    @(negedge clk);
    chk("R8 restart class", cls, 0);
    chk("R9 restart rg", rg, 1);
    wait_done();
    @(negedge clk);
    chk("R5 zero factor samples", n_smp - s0, TOTAL);
    ss = 0;
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule